// File: doc/BRIEF.md
# Two-over-pi segment extraction unit

This unit supplies one 53-bit piece of the binary expansion of 2/pi for range reduction of large trigonometric arguments. It takes a double-precision operand and a segment select. The operand's biased exponent and the select give a bit offset into a stored copy of 2/pi. The 53 bits found at that offset are returned as a positive double, scaled to the weight they carry in 2/pi. The downstream multiply-accumulate logic (not part of this block) can then multiply the argument by successive pieces without losing precision.

The offset is the amount by which the operand exponent exceeds a clamp, plus 53 times the segment number. If the required 96-bit window runs past the end of the stored bits, the result is zero. A fixed upward bias keeps the scale of the result representable when operand exponents are very large. Small results are denormalised with round-to-nearest-even. A NaN operand is passed back quieted. The result is registered, with a plain valid flag travelling alongside it.

Top module: `tpo_unit`

## Requirements
- R1: Only select bits [4:0] are used. A select of 0xFFFFFFE0 acts as segment 0, 0xFFFFFFFF acts as segment 31, and 0x00000022 acts as segment 2.
- R2: With E = operand[62:52], the offset is max(E-1077, 0) + 53*segment. The integer formed by the 53 bits of the 2/pi fraction at positions offset .. offset+52 (position 0 is the first bit after the binary point) is the result magnitude before scaling. Operand 0.0 with segment 0 gives 0x3FE45F306DC9C882, and with segment 2 gives 0x394A6EE06DB14ACC.
- R3: When (offset >> 5) + 2 >= 37, the result is +0.0. For E <= 1077 this holds for segments 22 to 31. For operand 0x6470000000000000 it holds from segment 12, and for operand 0x7B00000000000000 from segment 5.
- R4: The integer is scaled by 2^(-53-offset), or by 2^(75-offset) when E >= 0x7B0. Operand 0x7B00000000000000 with segment 0 gives 0x10374F463F669E5F. Operand 0x7950000000000000 with segment 2 gives 0x0343DD63F5F2F8BD.
- R5: An operand with all exponent bits set and a non-zero fraction returns the operand with bit 51 set. The sign bit and the payload are kept.
- R6: An infinite operand of either sign uses E = 0x7FF. With segment 0 it gives 0x0B43DD63F5F2F8BD.
- R7: A result below the normal range is denormalised with round-to-nearest-even. A result below half the smallest subnormal is +0.0.
- R8: Every result that is not a NaN has sign bit 0, whatever the sign of the operand.
- R9: valid_o is valid_i delayed by one clock. result_o is loaded only in a cycle with valid_i high and holds its value otherwise.
- R10: While rst_ni is low, valid_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and select are valid this cycle |
| operand_i | input | 64 | Double-precision operand |
| seg_i | input | 32 | Segment select; only bits [4:0] are used |
| valid_o | output | 1 | result_o holds a new result |
| result_o | output | 64 | Scaled 2/pi piece as a double |

## Verification
Every result, including the NaN, out-of-range and subnormal cases, is due exactly one rising edge after the cycle in which valid_i is sampled high. The bench drives each request on a falling edge and reads valid_o and result_o on the next falling edge, which is the first stable point after that rising edge. Idle cycles are then checked to show that the result is held. Reference values come from fixed vectors and from an independent model that uses host floating point; the model scales the 53-bit integer in two exact steps, so the only rounding is the final subnormal rounding.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int unsigned DBL_W     = 64;
  localparam int unsigned EXP_W     = 11;
  localparam int unsigned FRAC_W    = 52;
  localparam int unsigned SLICE_W   = FRAC_W + 1;
  localparam int unsigned EXP_BIAS  = 1023;
  localparam int unsigned WORD_W    = 32;

  // 2/pi fraction, most significant word first
  function automatic logic [WORD_W-1:0] tpo_rom_word(input int unsigned i);
    case (i)
      0:  return 32'ha2f9836e;  1:  return 32'h4e441529;  2:  return 32'hfc2757d1;
      3:  return 32'hf534ddc0;  4:  return 32'hdb629599;  5:  return 32'h3c439041;
      6:  return 32'hfe5163ab;  7:  return 32'hdebbc561;  8:  return 32'hb7246e3a;
      9:  return 32'h424dd2e0;  10: return 32'h06492eea;  11: return 32'h09d1921c;
      12: return 32'hfe1deb1c;  13: return 32'hb129a73e;  14: return 32'he88235f5;
      15: return 32'h2ebb4484;  16: return 32'he99c7026;  17: return 32'hb45f7e41;
      18: return 32'h3991d639;  19: return 32'h835339f4;  20: return 32'h9c845f8b;
      21: return 32'hbdf9283b;  22: return 32'h1ff897ff;  23: return 32'hde05980f;
      24: return 32'hef2f118b;  25: return 32'h5a0a6d1f;  26: return 32'h6d367ecf;
      27: return 32'h27cb09b7;  28: return 32'h4f463f66;  29: return 32'h9e5fea2d;
      30: return 32'h7527bac7;  31: return 32'hebe5f17b;  32: return 32'h3d0739f7;
      33: return 32'h8a5292ea;  34: return 32'h6bfb5fb1;  35: return 32'h1f8d5d08;
      36: return 32'h56033046;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tpo_offset.sv
module tpo_offset
  import tpo_pkg::*;
#(
  parameter int unsigned EXP_CLAMP = 1077,
  parameter int unsigned SEG_BITS  = 5,
  parameter int unsigned OFF_W     = 12
) (
  input  logic [EXP_W-1:0]    exp_i,
  input  logic [SEG_BITS-1:0] seg_i,
  output logic [OFF_W-1:0]    off_o
);
  logic [OFF_W-1:0] excess;
  always_comb begin
    if (OFF_W'(exp_i) > OFF_W'(EXP_CLAMP)) excess = OFF_W'(exp_i) - OFF_W'(EXP_CLAMP);
    else                                   excess = '0;
    off_o = excess + OFF_W'(SLICE_W) * OFF_W'(seg_i);
  end
endmodule

// File: rtl/tpo_window.sv
module tpo_window
  import tpo_pkg::*;
#(
  parameter int unsigned ROM_WORDS = 37,
  parameter int unsigned OFF_W     = 12
) (
  input  logic [OFF_W-1:0]   off_i,
  output logic               in_range_o,
  output logic [SLICE_W-1:0] slice_o
);
  localparam int unsigned SUB_W = $clog2(WORD_W);
  localparam int unsigned IDX_W = OFF_W - SUB_W;
  localparam int unsigned WIN_W = 3 * WORD_W;

  logic [WORD_W-1:0] rom [ROM_WORDS];
  for (genvar g = 0; g < ROM_WORDS; g++) begin : g_rom
    assign rom[g] = tpo_rom_word(g);
  end

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] w [3];
  logic [WIN_W-1:0]  win, win_sh;

  assign idx        = off_i[OFF_W-1:SUB_W];
  assign in_range_o = (32'(idx) + 32'd2) < ROM_WORDS;

  for (genvar k = 0; k < 3; k++) begin : g_fetch
    logic [IDX_W:0] pos;
    assign pos  = {1'b0, idx} + (IDX_W+1)'(k);
    assign w[k] = (32'(pos) < ROM_WORDS) ? rom[pos] : '0;
  end

  // 96-bit funnel: shift by sub-word offset, keep the top slice
  assign win     = {w[0], w[1], w[2]};
  assign win_sh  = win << off_i[SUB_W-1:0];
  assign slice_o = win_sh[WIN_W-1 -: SLICE_W];
endmodule

// File: rtl/tpo_pack.sv
module tpo_pack
  import tpo_pkg::*;
#(
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned BIAS_ADD = 128
) (
  input  logic [SLICE_W-1:0] slice_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               big_i,
  output logic [DBL_W-1:0]   result_o
);
  localparam int unsigned LZ_W     = $clog2(SLICE_W + 1);
  localparam int unsigned BE_W     = OFF_W + 3;
  localparam int unsigned EXP_BASE = EXP_BIAS - 1;
  localparam int unsigned PAD      = SLICE_W + 2;
  localparam int unsigned EXT_W    = SLICE_W + PAD;

  function automatic logic [LZ_W-1:0] lzc(input logic [SLICE_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(SLICE_W);
    for (int i = 0; i < SLICE_W; i++)
      if (v[i]) n = LZ_W'(SLICE_W - 1 - i);
    return n;
  endfunction

  logic [LZ_W-1:0]         lz;
  logic [SLICE_W-1:0]      sig;
  logic signed [BE_W-1:0]  be;
  logic [BE_W-1:0]         rsh;
  logic [LZ_W:0]           rsh_c;
  logic [EXT_W-1:0]        ext;
  logic [SLICE_W-1:0]      q, rnd;
  logic                    guard, sticky;

  always_comb begin
    lz  = lzc(slice_i);
    sig = slice_i << lz;
    be  = BE_W'(EXP_BASE) - BE_W'(lz) - BE_W'(off_i) + (big_i ? BE_W'(BIAS_ADD) : '0);
    rsh = BE_W'(1) - be;
    rsh_c  = (be > 0) ? '0 : ((rsh > BE_W'(PAD)) ? (LZ_W+1)'(PAD) : rsh[LZ_W:0]);
    ext    = {sig, {PAD{1'b0}}} >> rsh_c;
    q      = ext[EXT_W-1 -: SLICE_W];
    guard  = ext[PAD-1];
    sticky = |ext[PAD-2:0];
    rnd    = q + SLICE_W'(guard & (sticky | q[0]));
    if (slice_i == '0)  result_o = '0;
    else if (be > 0)    result_o = {1'b0, be[EXP_W-1:0], sig[FRAC_W-1:0]};
    else                result_o = DBL_W'(rnd);  // carry into exponent lsb is the smallest normal
  end
endmodule

// File: rtl/tpo_unit.sv
module tpo_unit
  import tpo_pkg::*;
#(
  parameter int unsigned SEL_W     = 32,
  parameter int unsigned SEG_BITS  = 5,
  parameter int unsigned ROM_WORDS = 37,
  parameter int unsigned EXP_CLAMP = 1077,
  parameter int unsigned BIG_EXP   = 'h7B0,
  parameter int unsigned BIAS_ADD  = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [63:0]      operand_i,
  input  logic [SEL_W-1:0] seg_i,
  output logic             valid_o,
  output logic [63:0]      result_o
);
  localparam int unsigned MAX_OFF = (2**EXP_W - 1 - EXP_CLAMP) + SLICE_W * (2**SEG_BITS - 1);
  localparam int unsigned OFF_W   = $clog2(MAX_OFF + 1);

  logic [EXP_W-1:0]   op_exp;
  logic               is_nan, big, in_range;
  logic [OFF_W-1:0]   off;
  logic [SLICE_W-1:0] slice;
  logic [DBL_W-1:0]   packed_val, nxt;

  assign op_exp = operand_i[DBL_W-2 -: EXP_W];
  assign is_nan = (&op_exp) && (|operand_i[FRAC_W-1:0]);
  assign big    = 32'(op_exp) >= BIG_EXP;

  tpo_offset #(.EXP_CLAMP(EXP_CLAMP), .SEG_BITS(SEG_BITS), .OFF_W(OFF_W)) u_off (
    .exp_i(op_exp), .seg_i(seg_i[SEG_BITS-1:0]), .off_o(off));

  tpo_window #(.ROM_WORDS(ROM_WORDS), .OFF_W(OFF_W)) u_win (
    .off_i(off), .in_range_o(in_range), .slice_o(slice));

  tpo_pack #(.OFF_W(OFF_W), .BIAS_ADD(BIAS_ADD)) u_pack (
    .slice_i(slice), .off_i(off), .big_i(big), .result_o(packed_val));

  always_comb begin
    if (is_nan)        nxt = operand_i | (DBL_W'(1) << (FRAC_W - 1));
    else if (in_range) nxt = packed_val;
    else               nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end
endmodule

module tpo_unit_chk #(
  parameter int unsigned SEL_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [63:0]      operand_i,
  input logic [SEL_W-1:0] seg_i,
  input logic             valid_o,
  input logic [63:0]      result_o
);
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r8_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && result_o[62:52] != 11'h7FF) |-> !result_o[63]);
  a_r5_nan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&operand_i[62:52]) && (|operand_i[51:0]))
      |=> result_o == ($past(operand_i) | 64'h0008_0000_0000_0000));
  a_r3_high_seg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && operand_i[62:52] <= 11'd1077 && !(&operand_i[62:52]) && seg_i[4:0] >= 5'd22)
      |=> result_o == 64'h0);
endmodule

bind tpo_unit tpo_unit_chk #(.SEL_W(SEL_W)) chk_i (.*);

// File: tb/tpo_unit_tb_top.sv
module tpo_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [31:0] seg_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_err = 0;
  logic [32*37-1:0] tbl;

  always #4 clk = ~clk;

  tpo_unit dut_i (.clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .operand_i(operand_i),
                  .seg_i(seg_i), .valid_o(valid_o), .result_o(result_o));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // independent model: bit-string slice, host floating-point scaling
  function automatic logic [63:0] ref_val(input logic [63:0] op, input logic [31:0] seg);
    int e, sh, sc;
    logic [52:0] m;
    real x;
    e = int'(op[62:52]);
    if (e == 2047 && op[51:0] != 0) return op | 64'h0008_0000_0000_0000;
    sh = (e > 1077 ? e - 1077 : 0) + 53 * int'(seg[4:0]);
    if ((sh >> 5) + 2 >= 37) return 64'h0;
    m = tbl[32*37-1-sh -: 53];
    if (m == 0) return 64'h0;
    sc = -53 - sh + (e >= 1968 ? 128 : 0);
    x = real'(longint'({11'b0, m})) * (2.0 ** real'(-600));
    x = x * (2.0 ** real'(sc + 600));
    return $realtobits(x);
  endfunction

  task automatic apply(input logic [63:0] op, input logic [31:0] seg, output logic [63:0] res);
    @(negedge clk);
    valid_i = 1'b1; operand_i = op; seg_i = seg;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R9 valid_o", {63'b0, valid_o}, 64'h1);
    res = result_o;
  endtask

  task automatic expect_val(input string req, input logic [63:0] op, input logic [31:0] seg,
                            input logic [63:0] exp);
    logic [63:0] r;
    apply(op, seg, r);
    chk(req, r, exp);
  endtask

  task automatic t_reset;
    chk("R10 valid_o in reset", {63'b0, valid_o}, 64'h0);
    chk("R10 result_o in reset", result_o, 64'h0);
  endtask

  task automatic t_slices;
    expect_val("R2 zero seg0", 64'h0, 32'd0, 64'h3FE45F306DC9C882);
    expect_val("R2 zero seg2", 64'h0, 32'd2, 64'h394A6EE06DB14ACC);
    expect_val("R2 E1607 seg0", 64'h6470000000000000, 32'd0, 64'h1EC8135A2FBF209C);
    expect_val("R2 E1607 seg2", 64'h6470000000000000, 32'd2, 64'h181272117E2EF7E4);
  endtask

  task automatic t_alias;
    expect_val("R1 seg -32", 64'h4070000000000000, 32'hFFFFFFE0, 64'h3FE45F306DC9C882);
    expect_val("R1 seg -1", 64'h4070000000000000, 32'hFFFFFFFF, 64'h0);
    expect_val("R1 seg 0x22", 64'h4070000000000000, 32'h00000022, 64'h394A6EE06DB14ACC);
  endtask

  task automatic t_bounds;
    expect_val("R3 zero seg21", 64'h0, 32'd21, ref_val(64'h0, 32'd21));
    expect_val("R3 zero seg22", 64'h0, 32'd22, 64'h0);
    expect_val("R3 E1607 seg11", 64'h6470000000000000, 32'd11, ref_val(64'h6470000000000000, 32'd11));
    expect_val("R3 E1607 seg12", 64'h6470000000000000, 32'd12, 64'h0);
    expect_val("R3 E1968 seg5", 64'h7B00000000000000, 32'd5, 64'h0);
  endtask

  task automatic t_bias;
    expect_val("R4 E1968 seg0", 64'h7B00000000000000, 32'd0, 64'h10374F463F669E5F);
    expect_val("R4 E1968 seg2", 64'h7B00000000000000, 32'd2, 64'h098F2F8BD9E839CE);
    expect_val("R4 E1941 seg2 unbiased", 64'h7950000000000000, 32'd2, 64'h0343DD63F5F2F8BD);
  endtask

  task automatic t_nan;
    expect_val("R5 snan", 64'h7FF0000000000001, 32'd0, 64'h7FF8000000000001);
    expect_val("R5 qnan", 64'h7FF8000000000000, 32'd7, 64'h7FF8000000000000);
    expect_val("R5 neg snan", 64'hFFF0000000000123, 32'd3, 64'hFFF8000000000123);
  endtask

  task automatic t_inf;
    expect_val("R6 +inf", 64'h7FF0000000000000, 32'd0, 64'h0B43DD63F5F2F8BD);
    expect_val("R6 -inf", 64'hFFF0000000000000, 32'd0, 64'h0B43DD63F5F2F8BD);
  endtask

  task automatic t_sign;
    expect_val("R8 negative operand", 64'hE470000000000000, 32'd0, 64'h1EC8135A2FBF209C);
    expect_val("R8 negative zero", 64'h8000000000000000, 32'd2, 64'h394A6EE06DB14ACC);
  endtask

  task automatic t_subnormal;
    expect_val("R7 underflow to zero", 64'h7AF0000000000000, 32'd4, 64'h0);
    for (int s = 17; s < 21; s++)
      for (int e = 1077; e < 1127; e += 7) begin
        logic [63:0] op;
        op = {1'b0, 11'(e), 52'h5};
        expect_val("R7 subnormal rounding", op, 32'(s), ref_val(op, 32'(s)));
      end
  endtask

  task automatic t_sweep;
    int exps [8] = '{0, 1077, 1078, 1100, 1500, 1967, 1968, 2047};
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 32; s++) begin
        logic [63:0] op;
        op = {1'b0, 11'(exps[i]), 52'h0};
        expect_val("R2 R4 sweep", op, 32'(s), ref_val(op, 32'(s)));
      end
  endtask

  task automatic t_hold;
    logic [63:0] r;
    apply(64'h0, 32'd0, r);
    operand_i = 64'h6470000000000000; seg_i = 32'd2;
    @(negedge clk);
    chk("R9 idle valid_o low", {63'b0, valid_o}, 64'h0);
    @(negedge clk);
    chk("R9 result held", result_o, 64'h3FE45F306DC9C882);
  endtask

  initial begin
    for (int i = 0; i < 37; i++) tbl[32*37-1-32*i -: 32] = tpo_pkg::tpo_rom_word(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_slices();
    t_alias();
    t_bounds();
    t_bias();
    t_nan();
    t_inf();
    t_sign();
    t_subnormal();
    t_sweep();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule